// File: doc/BRIEF.md
# Memory-Mapped 64-Source Interrupt Controller

This block gathers 64 interrupt inputs and drives one output line per source toward a parent controller. Each source is either level-sensitive, where its pending bit follows the input, or edge-sensitive, where a rising input edge latches the pending bit until software clears it. A source's output is high when its pending bit is set and its mask bit is clear.

Software reaches the block through a simple register bus. Reads and writes may be 1, 2, 4 or 8 bytes wide. The bus decodes every access against 8-byte registers. On a read, the selected register is shifted down by its byte lane and cut to the access width. On a write, only the addressed byte lanes of the register are merged in. The register file holds the following:

- a mask register, an edge-select register, a polarity register and a message-enable register;
- a write-only clear port;
- a read-only status view;
- a fixed identification word;
- two 64-byte storage arrays, one for routing and one for message vectors;
- two auto-control slots that are accepted and ignored.

Top module: `irq_hub`

## Requirements
- R1: A read of size S bytes (S = 1, 2, 4 or 8) at address A returns the 8-byte register at A with its low three bits cleared. That register is shifted right by 8×A[2:0] bits and masked to the low 8×S bits, and the value appears on `rdata` one cycle after the request. Unused upper bits are zero.
- R2: A write of size S at address A changes only bytes A[2:0] through A[2:0]+S−1 of the selected register. All other bytes keep their value.
- R3: The identification word at offset 0x00 reads as 0x003F_0001_0700_0000. This places the value 7 in byte 3, the value 1 in byte 4, and the source count minus one (63) in byte 6.
- R4: After reset, the mask (offset 0x20) reads as all ones, and both the message-enable (0x40) and edge-select (0x60) registers read as zero. No output is asserted, whatever the inputs are.
- R5: A read at offset 0x3A0 returns the pending bits ANDed with the inverted mask. Writes to 0x3A0 change neither the pending state nor the mask.
- R6: Reads from the auto-control slots at 0xC0 and 0xE0 return zero, and writes to them have no effect.
- R7: The following accesses are no-ops: any access whose size is not 1, 2, 4 or 8, and any access whose address is not a multiple of its size. A read of either kind returns zero.
- R8: Addresses outside the register map read as zero, and writes to them have no effect.
- R9: A source whose edge-select bit is 0 is level-sensitive. Its pending bit takes the input value at each clock edge, so its output follows the input one cycle later while it is unmasked.
- R10: A source whose edge-select bit is 1 sets its pending bit on a rising input edge. The bit stays set after the input falls.
- R11: A write to the clear port at 0x80 acts only if at least one written bit belongs to an edge-selected source. When it acts, it clears every written bit's pending state, and the affected outputs are low in the next cycle.
- R12: A mask write changes the outputs in the next cycle. A newly masked source goes low. A newly unmasked source goes high if its pending bit is set.
- R13: The routing array (0x100–0x13F) and the vector array (0x200–0x23F) are plain byte storage. They are read and written through the same lane rules as the other registers, and they do not affect the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Interrupt source inputs |
| req | input | 1 | Access request, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address within the block |
| size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| wdata | input | 64 | Write data, right-aligned to the access width |
| rdata | output | 64 | Read data, registered; holds until the next read |
| irq_out | output | 64 | Per-source interrupt outputs |

## Verification
The block has two latencies:

- **Read data** is registered. It is valid on `rdata` one clock after the cycle that carries `req`.
- **Register and pending updates** happen on the edge that ends the request or samples the input. An output change caused by a write, a mask change, a clear or an input edge is therefore visible one clock after that stimulus.

The bench drives every stimulus at a falling edge, lets exactly one rising edge pass, and samples at the following falling edge. Each result is therefore checked in the first cycle it is due. This timing also catches a level source that is wrongly dropped for a single cycle by a clear write that should have had no effect.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int DW        = 64;
    localparam int NSRC      = 64;
    localparam int ARR_WORDS = 8;
    localparam int OFFW      = $clog2(DW / 8);

    localparam logic [11:0] A_IDENT  = 12'h000;
    localparam logic [11:0] A_MASK   = 12'h020;
    localparam logic [11:0] A_MSIEN  = 12'h040;
    localparam logic [11:0] A_EDGE   = 12'h060;
    localparam logic [11:0] A_CLEAR  = 12'h080;
    localparam logic [11:0] A_ROUTE  = 12'h100;
    localparam logic [11:0] A_VECT   = 12'h200;
    localparam logic [11:0] A_STATUS = 12'h3A0;
    localparam logic [11:0] A_POL    = 12'h3E0;

    localparam logic [DW-1:0] IDENT_WORD =
        {8'h00, 8'(NSRC - 1), 8'h00, 8'h01, 8'h07, 24'h000000};

    typedef struct packed {
        logic [DW-1:0]                 mask;
        logic [DW-1:0]                 msien;
        logic [DW-1:0]                 edge_sel;
        logic [DW-1:0]                 pol;
        logic [NSRC-1:0]               pend;
        logic [NSRC-1:0]               in_prev;
        logic [ARR_WORDS-1:0][DW-1:0]  route;
        logic [ARR_WORDS-1:0][DW-1:0]  vect;
        logic [DW-1:0]                 rdata;
    } hub_state_t;
endpackage

// File: rtl/irq_hub_lane.sv
module irq_hub_lane
    import irq_hub_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    input  logic [DW-1:0]     wdata,
    output logic [ADDR_W-1:0] word_addr,
    output logic [OFFW-1:0]   lane_off,
    output logic [DW-1:0]     width_mask,
    output logic [DW-1:0]     lane_mask,
    output logic [DW-1:0]     lane_data,
    output logic              acc_ok
);
    logic size_legal;
    logic [OFFW-1:0] size_low;

    always_comb begin
        size_legal = 1'b1;
        case (size)
            4'd1:    width_mask = DW'(64'h0000_0000_0000_00FF);
            4'd2:    width_mask = DW'(64'h0000_0000_0000_FFFF);
            4'd4:    width_mask = DW'(64'h0000_0000_FFFF_FFFF);
            4'd8:    width_mask = '1;
            default: begin
                width_mask = '0;
                size_legal = 1'b0;
            end
        endcase
    end

    assign size_low   = size[OFFW-1:0];
    assign lane_off   = addr[OFFW-1:0];
    assign word_addr  = {addr[ADDR_W-1:OFFW], OFFW'(0)};
    assign acc_ok     = size_legal && ((lane_off & (size_low - OFFW'(1))) == '0);
    assign lane_mask  = width_mask << {lane_off, 3'b000};
    assign lane_data  = (wdata & width_mask) << {lane_off, 3'b000};
endmodule

// File: rtl/irq_hub_src.sv
module irq_hub_src
    import irq_hub_pkg::*;
(
    input  logic [NSRC-1:0] in_now,
    input  logic [NSRC-1:0] in_prev,
    input  logic [NSRC-1:0] edge_sel,
    input  logic [NSRC-1:0] pend_q,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend_d
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic rise;
        assign rise = in_now[i] & ~in_prev[i];
        assign pend_d[i] = edge_sel[i] ? ((pend_q[i] | rise) & ~clr[i])
                                       : (in_now[i] & ~clr[i]);
    end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_in,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [NSRC-1:0]   irq_out
);
    localparam int ARR_LSB = OFFW + $clog2(ARR_WORDS);

    hub_state_t s_d, s_q;

    logic [ADDR_W-1:0] word_addr;
    logic [OFFW-1:0]   lane_off;
    logic [DW-1:0]     width_mask, lane_mask, lane_data, rword;
    logic              acc_ok, rd_go, wr_go, in_route, in_vect;
    logic [$clog2(ARR_WORDS)-1:0] arr_idx;
    logic [NSRC-1:0]   clr_vec, pend_nx;
    logic [DW-1:0]     mask_now;

    irq_hub_lane #(.ADDR_W(ADDR_W)) i_lane (
        .addr       (addr),
        .size       (size),
        .wdata      (wdata),
        .word_addr  (word_addr),
        .lane_off   (lane_off),
        .width_mask (width_mask),
        .lane_mask  (lane_mask),
        .lane_data  (lane_data),
        .acc_ok     (acc_ok)
    );

    irq_hub_src i_src (
        .in_now   (irq_in),
        .in_prev  (s_q.in_prev),
        .edge_sel (s_q.edge_sel),
        .pend_q   (s_q.pend),
        .clr      (clr_vec),
        .pend_d   (pend_nx)
    );

    assign rd_go    = req && !wr && acc_ok;
    assign wr_go    = req && wr && acc_ok;
    assign in_route = word_addr[ADDR_W-1:ARR_LSB] == A_ROUTE[ADDR_W-1:ARR_LSB];
    assign in_vect  = word_addr[ADDR_W-1:ARR_LSB] == A_VECT[ADDR_W-1:ARR_LSB];
    assign arr_idx  = word_addr[ARR_LSB-1:OFFW];

    always_comb begin
        rword = '0;
        if      (word_addr == ADDR_W'(A_IDENT))  rword = IDENT_WORD;
        else if (word_addr == ADDR_W'(A_MASK))   rword = s_q.mask;
        else if (word_addr == ADDR_W'(A_MSIEN))  rword = s_q.msien;
        else if (word_addr == ADDR_W'(A_EDGE))   rword = s_q.edge_sel;
        else if (word_addr == ADDR_W'(A_STATUS)) rword = s_q.pend & ~s_q.mask;
        else if (word_addr == ADDR_W'(A_POL))    rword = s_q.pol;
        else if (in_route)                       rword = s_q.route[arr_idx];
        else if (in_vect)                        rword = s_q.vect[arr_idx];
    end

    always_comb begin
        s_d         = s_q;
        clr_vec     = '0;
        s_d.in_prev = irq_in;
        if (wr_go) begin
            if (word_addr == ADDR_W'(A_MASK))
                s_d.mask = (s_q.mask & ~lane_mask) | lane_data;
            else if (word_addr == ADDR_W'(A_MSIEN))
                s_d.msien = (s_q.msien & ~lane_mask) | lane_data;
            else if (word_addr == ADDR_W'(A_EDGE))
                s_d.edge_sel = (s_q.edge_sel & ~lane_mask) | lane_data;
            else if (word_addr == ADDR_W'(A_POL))
                s_d.pol = (s_q.pol & ~lane_mask) | lane_data;
            else if (word_addr == ADDR_W'(A_CLEAR)) begin
                if ((s_q.edge_sel & lane_data) != '0) clr_vec = lane_data;
            end
            else if (in_route)
                s_d.route[arr_idx] = (s_q.route[arr_idx] & ~lane_mask) | lane_data;
            else if (in_vect)
                s_d.vect[arr_idx] = (s_q.vect[arr_idx] & ~lane_mask) | lane_data;
        end
        s_d.pend = pend_nx;
        if (req && !wr)
            s_d.rdata = rd_go ? ((rword >> {lane_off, 3'b000}) & width_mask) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata    = s_q.rdata;
    assign irq_out  = s_q.pend & ~s_q.mask;
    assign mask_now = s_q.mask;
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
    import irq_hub_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        size,
    input logic [DW-1:0]     wdata,
    input logic [DW-1:0]     rdata,
    input logic [NSRC-1:0]   irq_out,
    input logic [DW-1:0]     mask_now
);
    AST_IDENT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr && addr == ADDR_W'(A_IDENT) && size == 4'd8) |=> (rdata == IDENT_WORD)); // R3

    AST_BAD_SIZE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr && !(size == 4'd1 || size == 4'd2 || size == 4'd4 || size == 4'd8))
        |=> (rdata == '0)); // R7

    AST_AUTO_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr && size == 4'd8 && (addr == ADDR_W'(12'h0C0) || addr == ADDR_W'(12'h0E0)))
        |=> (rdata == '0)); // R6

    AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr && addr == ADDR_W'(A_MASK) && size == 4'd8 && wdata == '1)
        |=> (irq_out == '0)); // R12

    AST_STATUS_WRITE_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr && addr == ADDR_W'(A_STATUS)) |=> $stable(mask_now)); // R5
endmodule

bind irq_hub irq_hub_chk #(.ADDR_W(ADDR_W)) i_irq_hub_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .wr       (wr),
    .addr     (addr),
    .size     (size),
    .wdata    (wdata),
    .rdata    (rdata),
    .irq_out  (irq_out),
    .mask_now (mask_now)
);

// File: tb/test_irq_hub.sv
module test_irq_hub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [3:0]  size = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [63:0] irq_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_hub i_irq_hub (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .req(req), .wr(wr),
        .addr(addr), .size(size), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    typedef struct packed {
        logic        w;
        logic [11:0] a;
        logic [3:0]  s;
        logic [63:0] d;
        logic [63:0] e;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 12'h000, 4'd8, 64'h0, 64'h003F_0001_0700_0000, 8'd3},   // R3
        '{1'b0, 12'h020, 4'd8, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd4},   // R4
        '{1'b0, 12'h040, 4'd8, 64'h0, 64'h0, 8'd4},                     // R4
        '{1'b0, 12'h060, 4'd8, 64'h0, 64'h0, 8'd4},                     // R4
        '{1'b1, 12'h060, 4'd8, 64'hF0, 64'h0, 8'd2},
        '{1'b0, 12'h060, 4'd8, 64'h0, 64'hF0, 8'd2},                    // R2
        '{1'b1, 12'h062, 4'd2, 64'hBEEF, 64'h0, 8'd2},
        '{1'b0, 12'h060, 4'd4, 64'h0, 64'hBEEF_00F0, 8'd2},             // R2
        '{1'b0, 12'h063, 4'd1, 64'h0, 64'hBE, 8'd1},                    // R1
        '{1'b1, 12'h3E1, 4'd1, 64'h5A, 64'h0, 8'd2},
        '{1'b0, 12'h3E0, 4'd8, 64'h0, 64'h5A00, 8'd2},                  // R2
        '{1'b1, 12'h13F, 4'd1, 64'h77, 64'h0, 8'd13},
        '{1'b0, 12'h138, 4'd8, 64'h0, 64'h7700_0000_0000_0000, 8'd13},  // R13
        '{1'b1, 12'h200, 4'd4, 64'h1122_3344, 64'h0, 8'd13},
        '{1'b0, 12'h201, 4'd1, 64'h0, 64'h33, 8'd13},                   // R13
        '{1'b1, 12'h0C0, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'd6},
        '{1'b0, 12'h0C0, 4'd8, 64'h0, 64'h0, 8'd6},                     // R6
        '{1'b1, 12'h3A0, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'd5},
        '{1'b0, 12'h3A0, 4'd8, 64'h0, 64'h0, 8'd5},                     // R5
        '{1'b1, 12'h060, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'd7},
        '{1'b0, 12'h060, 4'd8, 64'h0, 64'hBEEF_00F0, 8'd7},             // R7
        '{1'b0, 12'h060, 4'd3, 64'h0, 64'h0, 8'd7},                     // R7
        '{1'b1, 12'h061, 4'd2, 64'hFFFF, 64'h0, 8'd7},
        '{1'b0, 12'h060, 4'd8, 64'h0, 64'hBEEF_00F0, 8'd7},             // R7
        '{1'b1, 12'h300, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'd8},
        '{1'b0, 12'h300, 4'd8, 64'h0, 64'h0, 8'd8},                     // R8
        '{1'b1, 12'h040, 4'd8, 64'hAAAA, 64'h0, 8'd1},
        '{1'b0, 12'h044, 4'd4, 64'h0, 64'h0, 8'd1},                     // R1
        '{1'b0, 12'h040, 4'd2, 64'h0, 64'hAAAA, 8'd1},                  // R1
        '{1'b0, 12'h0E0, 4'd8, 64'h0, 64'h0, 8'd6}                      // R6
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [11:0] a, input logic [3:0] s,
                          input logic [63:0] d);
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; size = s; wdata = d;
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R4 irq_out after reset", irq_out, 64'h0);
        rst_n = 1'b1;
        irq_in = '1;
        repeat (3) @(negedge clk);
        check("R4 all inputs high under reset mask", irq_out, 64'h0);
        irq_in = '0;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            access(TBL[i].w, TBL[i].a, TBL[i].s, TBL[i].d);
            if (!TBL[i].w) begin
                total++;
                if (rdata !== TBL[i].e) begin
                    bad++;
                    $display("FAIL R%0d vector %0d actual=%h expected=%h",
                             TBL[i].rq, i, rdata, TBL[i].e);
                end
            end
        end

        // bit4 edge-sensitive, all others level; unmask sources 0, 1 and 4
        access(1'b1, 12'h060, 4'd8, 64'h10);
        access(1'b1, 12'h020, 4'd8, ~64'h13);

        @(negedge clk) irq_in[0] = 1'b1;
        @(negedge clk);
        check("R9 level source follows input high", irq_out, 64'h1);
        irq_in[0] = 1'b0;
        @(negedge clk);
        check("R9 level source follows input low", irq_out, 64'h0);

        irq_in[4] = 1'b1;
        @(negedge clk);
        irq_in[4] = 1'b0;
        check("R10 edge source latched", irq_out, 64'h10);
        @(negedge clk);
        check("R10 edge source held after input falls", irq_out, 64'h10);

        access(1'b0, 12'h3A0, 4'd8, 64'h0);
        check("R5 status shows unmasked pending", rdata, 64'h10);

        irq_in[1] = 1'b1;
        irq_in[9] = 1'b1;
        @(negedge clk);
        check("R5 masked source 9 kept out", irq_out, 64'h12);

        access(1'b1, 12'h080, 4'd8, 64'h2);
        check("R11 clear of level-only bits has no effect", irq_out, 64'h12);

        access(1'b1, 12'h080, 4'd1, 64'h10);
        check("R11 clear of edge source", irq_out, 64'h2);

        access(1'b1, 12'h020, 4'd1, 64'hFF);
        check("R12 newly masked source drops", irq_out, 64'h0);

        access(1'b1, 12'h020, 4'd1, 64'hEC);
        check("R12 unmasked source returns", irq_out, 64'h2);

        access(1'b0, 12'h020, 4'd8, 64'h0);
        check("R2 mask after byte writes", rdata, ~64'h13);

        irq_in = '0;
        done = 1'b1;
        summary();
    end
endmodule